// File: doc/BRIEF.md
# Four-bit ECC spare-area code packer

This block converts the raw parity of a 4-bit-correcting ECC engine into the ten code bytes stored in a NAND page's spare area. The engine reports one 512-byte chunk as four 32-bit words, and each word carries two 10-bit parity fields. The block pulls out the eight fields, interleaves them into ten bytes and writes them one per clock into a spare-area byte buffer. Each write carries a strobe, a byte address and a data byte.

Two spare layouts are supported:

- **Table layout.** Each code byte goes to a fixed spare offset that depends on the page size. On small pages the factory bad-block marker and the bytes reserved for software are skipped.
- **Infix layout.** Every chunk owns a 16-byte spare segment. The segment holds six 0xFF pad bytes followed by the ten code bytes.

The controller starts one conversion per chunk. It passes the raw words, the chunk index within the page, the layout and the page-size code. It then waits for `done_o`.

Top module: `ecc4_spare_packer`

## Requirements
- R1: A start request is taken only while `busy_o` is low. On the clock edge that takes it, the block captures all inputs. From the next cycle it asserts `wr_valid_o` for one byte per cycle, with no gaps, until the burst ends.
- R2: Each pair (p0, p1) is masked with 0x03FF03FF before packing. Its five bytes in order are:
  - p0[7:0]
  - {p0[21:16], p0[9:8]}
  - {p1[3:0], p0[25:22]}
  - {p1[17:16], p1[9:4]}
  - p1[25:18]
- R3: Word w of the raw input occupies `raw_ecc_i[32w+31:32w]`. Words 0 and 1 form the first pair and give code bytes 0 to 4. Words 2 and 3 form the second pair and give code bytes 5 to 9. Bits 31:26 and 15:10 of every word have no effect on the output.
- R4: In the table layout (`layout_i`=0) with page code 0 (512-byte page), code bytes 0 to 9 go to offsets 0, 1, 2, 3, 4, 6, 7, 13, 14 and 15 in that order. Offsets 5 and 8 to 12 are never written.
- R5: In the table layout with page code 1 (2048-byte page), code byte k goes to offset 24 + 10·c + k, where c is the chunk index.
- R6: In the table layout with page code 2 (4096-byte page), code byte k goes to offset 48 + 10·c + k. Page code 3 behaves like page code 2.
- R7: In the infix layout (`layout_i`=1), a burst writes 16 bytes at offsets 16·c to 16·c+15 in rising order. The first six bytes are 0xFF, and the last ten are code bytes 0 to 9.
- R8: The chunk index is reduced to the page's chunk count before use. For a 512-byte page it counts as 0. For a 2048-byte page only its two low bits count.
- R9: A table-layout burst is 10 bytes and an infix burst is 16 bytes. `done_o` is high for exactly the one cycle after the last byte. In that cycle `busy_o` and `wr_valid_o` are low.
- R10: A start request while `busy_o` is high is ignored. The running burst keeps its captured inputs, addresses and data.
- R11: After reset, `busy_o`, `wr_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request for one chunk |
| layout_i | input | 1 | 0 = table layout, 1 = infix layout |
| page_code_i | input | 2 | 0 = 512, 1 = 2048, 2 or 3 = 4096-byte page |
| chunk_i | input | CHUNK_W (3) | Chunk index within the page |
| raw_ecc_i | input | 128 | Four raw parity words, word 0 in the low bits |
| busy_o | output | 1 | Burst in progress |
| wr_valid_o | output | 1 | Byte write strobe |
| wr_addr_o | output | ADDR_W (7) | Spare-area byte offset |
| wr_data_o | output | 8 | Byte to write |
| done_o | output | 1 | One-cycle pulse after the last byte |

## Verification
Burst byte k appears on the outputs during the k-th cycle after the edge that takes the start request. `done_o` follows one cycle after byte 9 in the table layout, or after byte 15 in the infix layout. The bench samples every output on the falling clock edge. Its monitor pops one expected address and data pair from the scoreboard queue for each strobed byte. The driver counts falling edges from its start pulse, checks that `done_o` stays low until the cycle after the last byte, and in that cycle checks that `done_o` is high and the queue is empty. The busy-start case raises a second request two cycles into a burst, with different inputs, and relies on the same scoreboard to show that the first burst's bytes are unchanged.

// File: rtl/ecc4_pack_pkg.sv
package ecc4_pack_pkg;
  typedef enum logic {
    LAYOUT_TABLE = 1'b0,
    LAYOUT_INFIX = 1'b1
  } layout_e;

  typedef enum logic [1:0] {
    PG_512  = 2'd0,
    PG_2048 = 2'd1,
    PG_4096 = 2'd2,
    PG_RSVD = 2'd3
  } page_e;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned NUM_WORDS  = 4;
  localparam int unsigned NUM_PAIRS  = NUM_WORDS / 2;
  localparam int unsigned PAIR_BYTES = 5;
  localparam int unsigned CODE_BYTES = NUM_PAIRS * PAIR_BYTES;
  localparam int unsigned PAD_BYTES  = 6;
  localparam int unsigned SEG_BYTES  = PAD_BYTES + CODE_BYTES;
  localparam logic [WORD_W-1:0] FIELD_MASK = 32'h03FF_03FF;
endpackage

// File: rtl/ecc4_byte_interleave.sv
module ecc4_byte_interleave
  import ecc4_pack_pkg::*;
(
  input  logic [NUM_WORDS*WORD_W-1:0] raw_i,
  output logic [CODE_BYTES*8-1:0]     code_o
);
  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    logic [WORD_W-1:0] p0, p1;
    assign p0 = raw_i[(2*g)*WORD_W   +: WORD_W] & FIELD_MASK;
    assign p1 = raw_i[(2*g+1)*WORD_W +: WORD_W] & FIELD_MASK;

    assign code_o[(g*PAIR_BYTES+0)*8 +: 8] = p0[7:0];
    assign code_o[(g*PAIR_BYTES+1)*8 +: 8] = {p0[21:16], p0[9:8]};
    assign code_o[(g*PAIR_BYTES+2)*8 +: 8] = {p1[3:0], p0[25:22]};
    assign code_o[(g*PAIR_BYTES+3)*8 +: 8] = {p1[17:16], p1[9:4]};
    assign code_o[(g*PAIR_BYTES+4)*8 +: 8] = p1[25:18];
  end
endmodule

// File: rtl/ecc4_spare_addr.sv
module ecc4_spare_addr
  import ecc4_pack_pkg::*;
#(
  parameter int unsigned CHUNK_W = 3,
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned IDX_W   = 5
) (
  input  layout_e             layout_i,
  input  page_e               page_i,
  input  logic [CHUNK_W-1:0]  chunk_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                pad_o,
  output logic [IDX_W-1:0]    code_idx_o
);
  localparam int unsigned BASE_2K = 24;
  localparam int unsigned BASE_4K = 48;

  int unsigned chunk_eff;
  int unsigned idx;
  int unsigned addr_int;

  always_comb begin
    idx = int'(idx_i);
    unique case (page_i)
      PG_512:  chunk_eff = 0;
      PG_2048: chunk_eff = int'(chunk_i) & 3;
      default: chunk_eff = int'(chunk_i);
    endcase

    pad_o      = 1'b0;
    code_idx_o = idx_i;
    if (layout_i == LAYOUT_INFIX) begin
      addr_int = chunk_eff * SEG_BYTES + idx;
      pad_o    = (idx < PAD_BYTES);
      code_idx_o = pad_o ? '0 : IDX_W'(idx - PAD_BYTES);
    end else begin
      unique case (page_i)
        PG_512: begin
          // skip factory marker (5) and reserved 8..12
          if (idx < 5)      addr_int = idx;
          else if (idx < 7) addr_int = idx + 1;
          else              addr_int = idx + 6;
        end
        PG_2048: addr_int = BASE_2K + chunk_eff * CODE_BYTES + idx;
        default: addr_int = BASE_4K + chunk_eff * CODE_BYTES + idx;
      endcase
    end
    addr_o = ADDR_W'(addr_int);
  end
endmodule

// File: rtl/ecc4_emit_seq.sv
module ecc4_emit_seq #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] len_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [IDX_W-1:0] idx_q, last_q;

  assign accept_o = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        last_q <= len_i - 1'b1;
      end else if (busy_q) begin
        if (idx_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;

  assert_done_after_burst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  assert_idx_steps_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !$past(accept_o) && $past(busy_q) |-> idx_q == $past(idx_q) + 1'b1);
endmodule

// File: rtl/ecc4_spare_packer.sv
module ecc4_spare_packer
  import ecc4_pack_pkg::*;
#(
  parameter int unsigned CHUNK_W = 3,
  parameter int unsigned ADDR_W  = 7
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        layout_i,
  input  logic [1:0]                  page_code_i,
  input  logic [CHUNK_W-1:0]          chunk_i,
  input  logic [NUM_WORDS*WORD_W-1:0] raw_ecc_i,
  output logic                        busy_o,
  output logic                        wr_valid_o,
  output logic [ADDR_W-1:0]           wr_addr_o,
  output logic [7:0]                  wr_data_o,
  output logic                        done_o
);
  localparam int unsigned RAW_W = NUM_WORDS * WORD_W;
  localparam int unsigned IDX_W = $clog2(SEG_BYTES) + 1;

  logic                  accept;
  logic [IDX_W-1:0]      idx, code_idx, len;
  logic                  pad;
  layout_e               layout_q;
  page_e                 page_q;
  logic [CHUNK_W-1:0]    chunk_q;
  logic [RAW_W-1:0]      raw_q;
  logic [CODE_BYTES*8-1:0] code;
  logic [7:0]            code_byte;

  assign len = (layout_i == LAYOUT_INFIX) ? IDX_W'(SEG_BYTES) : IDX_W'(CODE_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      layout_q <= LAYOUT_TABLE;
      page_q   <= PG_512;
      chunk_q  <= '0;
      raw_q    <= '0;
    end else if (accept) begin
      layout_q <= layout_e'(layout_i);
      page_q   <= page_e'(page_code_i);
      chunk_q  <= chunk_i;
      raw_q    <= raw_ecc_i;
    end
  end

  ecc4_emit_seq #(.IDX_W(IDX_W)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .len_i    (len),
    .accept_o (accept),
    .busy_o   (busy_o),
    .idx_o    (idx),
    .done_o   (done_o)
  );

  ecc4_byte_interleave i_ilv (
    .raw_i  (raw_q),
    .code_o (code)
  );

  ecc4_spare_addr #(.CHUNK_W(CHUNK_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_addr (
    .layout_i   (layout_q),
    .page_i     (page_q),
    .chunk_i    (chunk_q),
    .idx_i      (idx),
    .addr_o     (wr_addr_o),
    .pad_o      (pad),
    .code_idx_o (code_idx)
  );

  assign code_byte  = code[{code_idx, 3'b000} +: 8];
  assign wr_data_o  = pad ? 8'hFF : code_byte;
  assign wr_valid_o = busy_o;

  assert_start_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> wr_valid_o);
  assert_skip_marker_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && layout_q == LAYOUT_TABLE && page_q == PG_512
    |-> wr_addr_o != 5 && (wr_addr_o < 8 || wr_addr_o > 12));
  assert_table_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && $past(wr_valid_o) && layout_q == LAYOUT_TABLE && page_q != PG_512
    |-> wr_addr_o == ADDR_W'($past(wr_addr_o) + 1'b1));
  assert_pad_ff_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && layout_q == LAYOUT_INFIX && wr_addr_o[3:0] < 4'd6 |-> wr_data_o == 8'hFF);
  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(raw_q) && $stable(chunk_q) && $stable(layout_q));
endmodule

// File: tb/test_ecc4_spare_packer.sv
module test_ecc4_spare_packer;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         layout_i = 1'b0;
  logic [1:0]   page_code_i = 2'd0;
  logic [2:0]   chunk_i = 3'd0;
  logic [127:0] raw_ecc_i = '0;
  logic         busy_o, wr_valid_o, done_o;
  logic [6:0]   wr_addr_o;
  logic [7:0]   wr_data_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [6:0] a;
    logic [7:0] d;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk_i = ~clk_i;

  ecc4_spare_packer i_ecc4_spare_packer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .layout_i(layout_i),
    .page_code_i(page_code_i), .chunk_i(chunk_i), .raw_ecc_i(raw_ecc_i),
    .busy_o(busy_o), .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_code(input logic [127:0] raw, input int k);
    logic [31:0] p0, p1;
    int pr, j;
    pr = k / 5;
    j  = k % 5;
    p0 = raw[64*pr +: 32] & 32'h03FF03FF;
    p1 = raw[64*pr+32 +: 32] & 32'h03FF03FF;
    case (j)
      0: return p0[7:0];
      1: return {p0[21:16], p0[9:8]};
      2: return {p1[3:0], p0[25:22]};
      3: return {p1[17:16], p1[9:4]};
      default: return p1[25:18];
    endcase
  endfunction

  // R8: chunk reduced per page size
  function automatic int eff_chunk(input logic [1:0] pg, input logic [2:0] ch);
    if (pg == 2'd0) return 0;
    if (pg == 2'd1) return int'(ch[1:0]);
    return int'(ch);
  endfunction

  task automatic run_chunk(input bit lay, input logic [1:0] pg, input logic [2:0] ch,
                           input logic [127:0] raw, input bit poke, input string tag);
    int n, c, a;
    item_t it;
    n = lay ? 16 : 10;
    c = eff_chunk(pg, ch);
    for (int k = 0; k < n; k++) begin
      if (lay) begin
        a = 16 * c + k;
        it.d = (k < 6) ? 8'hFF : exp_code(raw, k - 6);
      end else begin
        if (pg == 2'd0)      a = (k < 5) ? k : (k < 7) ? k + 1 : k + 6;
        else if (pg == 2'd1) a = 24 + 10 * c + k;
        else                 a = 48 + 10 * c + k;
        it.d = exp_code(raw, k);
      end
      it.a = 7'(a);
      it.tag = tag;
      sb_q.push_back(it);
    end
    @(negedge clk_i);
    layout_i = lay; page_code_i = pg; chunk_i = ch; raw_ecc_i = raw; start_i = 1'b1;
    for (int k = 0; k <= n; k++) begin
      @(negedge clk_i);
      if (k == 0) start_i = 1'b0;
      if (poke && k == 2) begin
        start_i = 1'b1; layout_i = ~lay; page_code_i = pg + 2'd1;
        chunk_i = ch + 3'd1; raw_ecc_i = ~raw;
      end
      if (poke && k == 3) start_i = 1'b0;
      if (k < n) begin
        chk(done_o == 1'b0, {tag, " R9 done early"}, done_o, 0);
      end else begin
        chk(done_o == 1'b1 && busy_o == 1'b0 && wr_valid_o == 1'b0,
            {tag, " R9 done pulse"}, {done_o, busy_o, wr_valid_o}, 3'b100);
        chk(sb_q.size() == 0, {tag, " R9 byte count"}, sb_q.size(), 0);
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && wr_valid_o) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R1 unexpected byte", {wr_addr_o, wr_data_o}, 0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk(wr_addr_o == it.a, {it.tag, " address"}, wr_addr_o, it.a);
        chk(wr_data_o == it.d, {it.tag, " data"}, wr_data_o, it.d);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && wr_valid_o == 0 && done_o == 0, "R11 reset state",
        {busy_o, wr_valid_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 0 && wr_valid_o == 0 && done_o == 0, "R11 idle after reset",
        {busy_o, wr_valid_o, done_o}, 0);

    run_chunk(0, 2'd0, 3'd0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 0, "R2 R3 R4 table 512");
    run_chunk(0, 2'd0, 3'd5, '1, 0, "R3 R4 R8 table 512 ones");
    run_chunk(0, 2'd1, 3'd0, 128'h0000_0001_0000_0200_0001_0000_0200_0000, 0, "R2 R5 table 2048 c0");
    run_chunk(0, 2'd1, 3'd3, 128'h03FF_0000_0000_03FF_0155_02AA_02AA_0155, 0, "R5 table 2048 c3");
    run_chunk(0, 2'd1, 3'd6, 128'hDEAD_BEEF_CAFE_F00D_1234_5678_9ABC_DEF0, 0, "R5 R8 table 2048 c6");
    run_chunk(0, 2'd2, 3'd7, 128'h1111_2222_3333_4444_5555_6666_7777_8888, 0, "R6 table 4096 c7");
    run_chunk(0, 2'd3, 3'd1, 128'hA5A5_5A5A_0F0F_F0F0_3C3C_C3C3_9696_6969, 0, "R6 table code3 c1");
    run_chunk(1, 2'd0, 3'd3, 128'h0246_8ACE_1357_9BDF_FDB9_7531_ECA8_6420, 0, "R7 R8 infix 512");
    run_chunk(1, 2'd1, 3'd2, 128'h0000_0000_0000_0000_0000_0000_0000_0000, 0, "R7 infix 2048 c2");
    run_chunk(1, 2'd2, 3'd7, 128'h7FFF_0001_8000_FFFE_0102_0304_0506_0708, 0, "R7 infix 4096 c7");
    run_chunk(0, 2'd1, 3'd1, 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0, 1, "R10 table busy start");
    run_chunk(1, 2'd1, 3'd1, 128'h1020_3040_5060_7080_90A0_B0C0_D0E0_F000, 1, "R10 infix busy start");

    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && wr_valid_o == 0 && sb_q.size() == 0, "R10 no extra burst",
        {busy_o, wr_valid_o}, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule